// File: doc/BRIEF.md
# Pattern-Armed Complement Window

This block watches a serial control line for the bit sequence 1, 0, 1. When the final 1 of that sequence is sampled, it opens a timed window that lasts a fixed number of clock cycles (16 by default). While the window is open, the output follows the inverse of a second serial data line. At all other times the output is forced low.

While a window runs, the control line is not looked at. A trigger sequence that appears inside the window is lost. It can neither restart nor lengthen the window. When the window closes, the pattern search starts again from a clean state, so no partial match is kept from before or during the window.

The window is timed by a binary up-counter. Its width comes from the window length, which must be a power of two. All state is held in rising-edge flip-flops with a synchronous, active-high reset.

Top module: `armed_window_top`

## Requirements
- R1: While `rst` is high at a rising edge, the detector, the counter and the window flag are cleared. From the next cycle `y` is 0, and control bits seen before or during reset cannot complete a trigger.
- R2: The trigger is `trig_a` sampled as 1, then 0, then 1 on consecutive rising edges while no window is open. The window is open starting in the cycle after the edge that samples the final 1.
- R3: While the window is open, `y` equals the inverse of `dat_b` in the same cycle. The window stays open for exactly WIN_LEN cycles (16 by default), after which the counter wraps to 0 and the window closes.
- R4: Whenever no window is open, `y` is 0 whatever `dat_b` is.
- R5: A partial match restarts correctly. Extra leading 1s are tolerated ("1101" triggers on its last bit), a "00" breaks the match, and "10101" triggers on its third bit.
- R6: The value of `trig_a` while a window is open has no effect. A 1, 0, 1 inside the window neither restarts nor extends it, and `y` drops after exactly WIN_LEN cycles.
- R7: When a window closes, detection restarts from idle. Control bits sampled during the window, including its last cycle, do not count toward a new trigger.
- R8: A trigger that starts in the first cycle after a window closes opens a new window in the cycle after its final 1.
- R9: A synchronous reset asserted in the middle of a window closes it. `y` is 0 in the cycle after the reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_a | input | 1 | Serial control line searched for 1, 0, 1 |
| dat_b | input | 1 | Serial data line, inverted onto `y` inside the window |
| y | output | 1 | Inverse of `dat_b` inside the window, 0 outside it |

## Verification
The bench drives a long stream and checks `y` in every cycle against a reference model. The model keeps only the raw control bits seen since the last idle point and a count of remaining window cycles. It goes after four kinds of error:
- An off-by-one window. This would show as a stray `~dat_b` value on cycle 17, or a missing one on cycle 1.
- A detector that keeps watching during the window. This would extend or restart the window when 1, 0, 1 is fed inside it.
- A detector that keeps history across the window. This would fire on "0, 1" right after a window whose last control bit was 1.
- Reset that does not reach the window flag. This would leave `y` active after a mid-window reset.

// File: rtl/armed_window_pkg.sv
package armed_window_pkg;

   typedef enum logic [1:0] {
      DET_IDLE    = 2'd0,
      DET_GOT1    = 2'd1,
      DET_GOT10   = 2'd2
   } det_state_e;

   localparam int unsigned TRIG_BITS = 3;

endpackage

// File: rtl/armed_seq_detect.sv
module armed_seq_detect
   import armed_window_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic hold,
   input  logic a_in,
   output logic fire
);

   det_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      fire = 1'b0;
      if (hold) begin
         st_d = DET_IDLE;
      end else begin
         unique case (st_q)
            DET_IDLE:  st_d = a_in ? DET_GOT1 : DET_IDLE;
            DET_GOT1:  st_d = a_in ? DET_GOT1 : DET_GOT10;
            DET_GOT10: begin
               if (a_in) begin
                  fire = 1'b1;
                  st_d = DET_IDLE;
               end else begin
                  st_d = DET_IDLE;
               end
            end
            default:   st_d = DET_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= DET_IDLE;
      else     st_q <= st_d;
   end

   // R2: a fire is always followed by an idle detector
   p_fire_to_idle_r2: assert property (@(posedge clk) disable iff (rst)
      fire |=> (st_q == DET_IDLE));

   // R7: while held, the detector comes out idle
   p_hold_clears_r7: assert property (@(posedge clk) disable iff (rst)
      hold |=> (st_q == DET_IDLE));

endmodule

// File: rtl/armed_window_timer.sv
module armed_window_timer #(
   parameter int unsigned WIN_LEN = 16,
   localparam int unsigned CNT_W  = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic active
);

   generate
      if (WIN_LEN < 2 || (1 << CNT_W) != WIN_LEN) begin : g_bad_len
         $error("armed_window_timer: WIN_LEN must be a power of two >= 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W:0]   carry;
   logic             act_q;

   assign carry[0] = 1'b1;

   generate
      for (genvar gi = 0; gi < CNT_W; gi++) begin : g_cnt_bit
         assign cnt_inc[gi]  = cnt_q[gi] ^ carry[gi];
         assign carry[gi+1]  = carry[gi] & cnt_q[gi];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         act_q <= 1'b1;
         cnt_q <= '0;
      end else if (act_q) begin
         cnt_q <= cnt_inc;
         if (carry[CNT_W]) act_q <= 1'b0;
      end
   end

   assign active = act_q;

   // R2: every window begins at count zero
   p_open_at_zero_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(act_q) |-> (cnt_q == '0));

   // R3: window closes right after the terminal count
   p_close_at_wrap_r3: assert property (@(posedge clk) disable iff (rst)
      (act_q && !start && cnt_q == {CNT_W{1'b1}}) |=> (!act_q && cnt_q == '0));

   // R3: inside the window the count advances by one
   p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
      (act_q && !start && cnt_q != {CNT_W{1'b1}}) |=> (act_q && cnt_q == $past(cnt_q) + 1'b1));

   // R6: no start request can arrive while a window runs
   p_no_restart_r6: assert property (@(posedge clk) disable iff (rst)
      !(start && act_q));

endmodule

// File: rtl/armed_window_top.sv
module armed_window_top #(
   parameter int unsigned WIN_LEN = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic trig_a,
   input  logic dat_b,
   output logic y
);

   logic fire;
   logic win_on;

   armed_seq_detect i_detect (
      .clk   (clk),
      .rst   (rst),
      .hold  (win_on),
      .a_in  (trig_a),
      .fire  (fire)
   );

   armed_window_timer #(
      .WIN_LEN (WIN_LEN)
   ) i_timer (
      .clk    (clk),
      .rst    (rst),
      .start  (fire),
      .active (win_on)
   );

   assign y = win_on & ~dat_b;

   // R2: a completed trigger opens the window next cycle
   p_fire_opens_r2: assert property (@(posedge clk) disable iff (rst)
      fire |=> win_on);

   // R9: reset edge leaves the window closed
   p_reset_closes_r9: assert property (@(posedge clk)
      rst |=> !win_on);

   // R4: no output while the window is shut
   p_quiet_outside_r4: assert property (@(posedge clk) disable iff (rst)
      (!win_on) |-> (y == 1'b0));

endmodule

// File: tb/test_armed_window_top.sv
module test_armed_window_top;

   localparam int WIN = 16;
   localparam int WATCHDOG_CYC = 50000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic trig_a = 1'b0;
   logic dat_b = 1'b0;
   logic y;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   armed_window_top #(.WIN_LEN(WIN)) i_armed_window_top (
      .clk    (clk),
      .rst    (rst),
      .trig_a (trig_a),
      .dat_b  (dat_b),
      .y      (y)
   );

   typedef struct {
      logic  exp;
      logic  bval;
      string tag;
   } item_t;

   item_t sb_q[$];

   // reference model state
   int       m_rem = 0;
   logic [2:0] m_hist = 3'b000;
   int       m_hlen = 0;

   task automatic cyc(input logic a_v, input logic b_v, input logic r_v, input string tag);
      item_t it;
      rst    = r_v;
      trig_a = a_v;
      dat_b  = b_v;
      it.exp  = (m_rem > 0) && !b_v;
      it.bval = b_v;
      it.tag  = tag;
      sb_q.push_back(it);
      @(posedge clk);
      if (r_v) begin
         m_rem = 0; m_hlen = 0; m_hist = 3'b000;
      end else if (m_rem > 0) begin
         m_rem--; m_hlen = 0; m_hist = 3'b000;
      end else begin
         m_hist = {m_hist[1:0], a_v};
         m_hlen++;
         if (m_hlen >= 3 && m_hist == 3'b101) begin
            m_rem = WIN; m_hlen = 0; m_hist = 3'b000;
         end
      end
      #1;
   endtask

   task automatic stream(input logic [63:0] av, input logic [63:0] bv, input int n, input string tag);
      for (int i = n - 1; i >= 0; i--) cyc(av[i], bv[i], 1'b0, tag);
   endtask

   // monitor: pops expected items and compares away from the edge
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         checks++;
         if (y !== it.exp) begin
            failures++;
            $display("FAIL %s: y actual=%b expected=%b (dat_b=%b) t=%0t",
                     it.tag, y, it.exp, it.bval, $time);
         end
      end
   end

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      @(posedge clk); #1;
      // R1: reset while a 1,0,1 goes by, then "0,1" must not fire
      cyc(1'b1, 1'b0, 1'b1, "R1");
      cyc(1'b0, 1'b0, 1'b1, "R1");
      cyc(1'b1, 1'b0, 1'b1, "R1");
      cyc(1'b0, 1'b0, 1'b0, "R1");
      cyc(1'b1, 1'b0, 1'b0, "R1");
      cyc(1'b0, 1'b0, 1'b0, "R1");
      cyc(1'b0, 1'b0, 1'b0, "R1");

      // R2/R3/R4: reference stream
      stream(64'h0000_0000_3269_2AE7, 64'h0000_0000_B38F_0F83, 32, "R2_R3_R4");
      repeat (20) cyc(1'b0, 1'b1, 1'b0, "R4");

      // R5: leading 1s ("1101")
      stream(64'h0D, 64'h00, 4, "R5");
      for (int i = 0; i < WIN; i++) cyc(1'b0, i[0] ^ i[2], 1'b0, "R3");
      // R5: "00" breaks a match, then "10101"
      stream(64'h09, 64'h00, 4, "R5");
      stream(64'h15, 64'h00, 5, "R5");
      // R6: 1,0,1 repeatedly inside the window
      for (int i = 0; i < WIN; i++) cyc((i % 3) != 1, 1'b0, 1'b0, "R6");
      // R7: last window bit was 1 above? make it explicit on next window
      cyc(1'b0, 1'b0, 1'b0, "R4");
      stream(64'h05, 64'h00, 3, "R2");
      for (int i = 0; i < WIN; i++) cyc(i == WIN - 1, i[1], 1'b0, "R7");
      stream(64'h04, 64'h00, 4, "R7");   // 0,1,0,0: no trigger
      repeat (4) cyc(1'b0, 1'b0, 1'b0, "R7");

      // R8: trigger right after a window closes
      stream(64'h05, 64'h00, 3, "R2");
      for (int i = 0; i < WIN; i++) cyc(1'b0, 1'b0, 1'b0, "R3");
      stream(64'h05, 64'h00, 3, "R8");
      for (int i = 0; i < WIN; i++) cyc(1'b0, i[0], 1'b0, "R8");
      repeat (3) cyc(1'b0, 1'b0, 1'b0, "R8");

      // R9: reset in mid-window
      stream(64'h05, 64'h00, 3, "R2");
      repeat (5) cyc(1'b0, 1'b0, 1'b0, "R9");
      cyc(1'b0, 1'b0, 1'b1, "R9");
      repeat (12) cyc(1'b0, 1'b0, 1'b0, "R9");

      // R3/R5/R6: pseudo-random traffic
      lfsr = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cyc(lfsr[0], lfsr[5], 1'b0, "R3_R6");
      end

      @(negedge clk);
      #1;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule